// File: doc/BRIEF.md
# Thread-Block Slot Dispatcher

This block hands the thread blocks of one kernel grid to a row of compute cores. When a kernel starts, it works out how many blocks a single core can hold at once. That number is the smallest of three limits: how many blocks fit in the core's register file, how many fit in its shared memory, and a fixed number of hardware slots. The block then hands out block indices in ascending order until every core is full or the grid runs out.

After the initial fill, a core receives a new block only when it reports that one of its resident blocks has finished. Cores are visited in round-robin order. Each core's occupancy is tracked on its own, because blocks on different cores run independently. The block issues at most one dispatch command per cycle. It raises a done level once every block of the grid has retired. It raises an error level instead when not even one block fits on a core.

Top module: `blk_dispatch`

## Requirements
- R1: At launch the per-core resident limit is min(core_regs / regs_per_blk, core_smem / smem_per_blk, SLOT_MAX). A per-block demand of zero removes that resource from the minimum.
- R2: No core ever holds more than SLOT_MAX (default 8) resident blocks, even when neither resource limits residency.
- R3: Dispatched block indices start at 0 and rise by one per dispatch. Exactly grid_blocks dispatches are made for a kernel.
- R4: While several cores have room, dispatches rotate over the cores starting from core 0. Each search begins at the core after the one last granted.
- R5: A core at its limit receives no block until it retires one. The freed slot is refilled in the cycle after the retire is sampled.
- R6: After reset disp_valid, kern_done and kern_err are low. At most one dispatch command is issued per cycle.
- R7: If the resident limit computes to zero, kern_err goes high in the cycle after launch and nothing is dispatched. The next launch clears kern_err.
- R8: kern_done goes high in the cycle after the last block of the grid retires and stays high until the next launch. A grid of zero blocks raises kern_done in the cycle after launch.
- R9: A retire pulse for a core that holds no block is ignored and does not count toward completion.
- R10: A launch that arrives while a kernel is still running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| launch | input | 1 | One-cycle pulse that starts a kernel with the values below |
| grid_blocks | input | BLK_W | Number of blocks in the grid |
| regs_per_blk | input | RES_W | Registers one block needs (0 = no limit) |
| smem_per_blk | input | RES_W | Shared memory one block needs (0 = no limit) |
| core_regs | input | RES_W | Register capacity of each core |
| core_smem | input | RES_W | Shared memory capacity of each core |
| retire_vec | input | NUM_CORES | One bit per core: a resident block finished this cycle |
| disp_valid | output | 1 | A dispatch command is present |
| disp_blk | output | BLK_W | Index of the dispatched block |
| disp_core | output | CORE_W | Target core of the dispatched block |
| kern_done | output | 1 | All blocks of the kernel have retired |
| kern_err | output | 1 | The resident limit is zero; the kernel cannot run |

## Verification
The bench builds the block with its defaults: four cores, eight slots and 16-bit indices and resource fields. With four cores, the rotation wraps several times within a short grid, so the choice of refill target among several freed cores can be observed. Resource values are chosen so that each of the three limits is the binding one in turn: registers give 4, shared memory gives 2, and the slot count gives 8. A register demand above capacity drives the limit to zero.

// File: rtl/bd_pkg.sv
package bd_pkg;
  typedef enum logic [1:0] {
    BD_IDLE  = 2'd0,
    BD_RUN   = 2'd1,
    BD_FIN   = 2'd2,
    BD_FAULT = 2'd3
  } bd_state_e;
endpackage

// File: rtl/bd_limit_calc.sv
module bd_limit_calc #(
  parameter int RES_W    = 16,
  parameter int SLOT_MAX = 8,
  parameter int LIM_W    = 4
) (
  input  logic [RES_W-1:0] regs_cap,
  input  logic [RES_W-1:0] regs_need,
  input  logic [RES_W-1:0] smem_cap,
  input  logic [RES_W-1:0] smem_need,
  output logic [LIM_W-1:0] lim
);
  localparam int NRES = 2;

  logic [RES_W-1:0] cap_a  [NRES];
  logic [RES_W-1:0] need_a [NRES];
  logic [RES_W-1:0] fit_a  [NRES];
  logic [RES_W-1:0] best;

  assign cap_a[0]  = regs_cap;
  assign need_a[0] = regs_need;
  assign cap_a[1]  = smem_cap;
  assign need_a[1] = smem_need;

  // one quotient per resource; zero demand never limits
  for (genvar r = 0; r < NRES; r++) begin : g_res
    assign fit_a[r] = (need_a[r] == '0) ? RES_W'(SLOT_MAX) : cap_a[r] / need_a[r];
  end

  always_comb begin
    best = RES_W'(SLOT_MAX);
    for (int r = 0; r < NRES; r++) begin
      if (fit_a[r] < best) best = fit_a[r];
    end
    lim = best[LIM_W-1:0];
  end
endmodule

// File: rtl/bd_core_tracker.sv
module bd_core_tracker #(
  parameter int NUM_CORES = 4,
  parameter int LIM_W     = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic [NUM_CORES-1:0] grant_vec,
  input  logic [NUM_CORES-1:0] retire_vec,
  input  logic [LIM_W-1:0]     limit,
  output logic [NUM_CORES-1:0] room_vec,
  output logic [NUM_CORES-1:0] acc_vec
);
  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic [LIM_W-1:0] occ_q, occ_n;
    logic             occ_en;

    assign acc_vec[c]  = retire_vec[c] & (occ_q != '0);
    assign room_vec[c] = (occ_q < limit);
    assign occ_en      = clr | grant_vec[c] | acc_vec[c];

    always_comb begin
      if (clr) occ_n = '0;
      else     occ_n = occ_q + LIM_W'(grant_vec[c]) - LIM_W'(acc_vec[c]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      occ_q <= '0;
      else if (occ_en) occ_q <= occ_n;
    end
  end
endmodule

// File: rtl/bd_rr_pick.sv
module bd_rr_pick #(
  parameter int NUM_CORES = 4,
  parameter int CORE_W    = 2
) (
  input  logic [NUM_CORES-1:0] req,
  input  logic [CORE_W-1:0]    ptr,
  output logic                 hit,
  output logic [CORE_W-1:0]    idx
);
  // scan from ptr upward with wrap; the nearest requester wins
  always_comb begin
    int c;
    hit = 1'b0;
    idx = ptr;
    for (int k = NUM_CORES - 1; k >= 0; k--) begin
      c = (int'(ptr) + k) % NUM_CORES;
      if (req[c]) begin
        hit = 1'b1;
        idx = CORE_W'(c);
      end
    end
  end
endmodule

// File: rtl/blk_dispatch.sv
module blk_dispatch #(
  parameter int NUM_CORES = 4,
  parameter int SLOT_MAX  = 8,
  parameter int BLK_W     = 16,
  parameter int RES_W     = 16,
  localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 launch,
  input  logic [BLK_W-1:0]     grid_blocks,
  input  logic [RES_W-1:0]     regs_per_blk,
  input  logic [RES_W-1:0]     smem_per_blk,
  input  logic [RES_W-1:0]     core_regs,
  input  logic [RES_W-1:0]     core_smem,
  input  logic [NUM_CORES-1:0] retire_vec,
  output logic                 disp_valid,
  output logic [BLK_W-1:0]     disp_blk,
  output logic [CORE_W-1:0]    disp_core,
  output logic                 kern_done,
  output logic                 kern_err
);
  import bd_pkg::*;

  localparam int LIM_W = $clog2(SLOT_MAX + 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  bd_state_e          st_q, st_n;
  logic [LIM_W-1:0]   lim_q, lim_n, lim_calc;
  logic [BLK_W-1:0]   grid_q, grid_n;
  logic [BLK_W-1:0]   nxt_q, nxt_n;
  logic [BLK_W-1:0]   fin_q, fin_n;
  logic [CORE_W-1:0]  ptr_q, ptr_n;
  logic               ctl_en;

  logic                 clr, fire, hit;
  logic [CORE_W-1:0]    pick_idx;
  logic [NUM_CORES-1:0] grant_vec, room_vec, acc_vec;
  logic [BLK_W-1:0]     retired_cnt;

  logic               dv_q;
  logic [BLK_W-1:0]   db_q;
  logic [CORE_W-1:0]  dc_q;

  bd_limit_calc #(.RES_W(RES_W), .SLOT_MAX(SLOT_MAX), .LIM_W(LIM_W)) limit_i (
    .regs_cap (core_regs),
    .regs_need(regs_per_blk),
    .smem_cap (core_smem),
    .smem_need(smem_per_blk),
    .lim      (lim_calc)
  );

  bd_core_tracker #(.NUM_CORES(NUM_CORES), .LIM_W(LIM_W)) track_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .clr       (clr),
    .grant_vec (grant_vec),
    .retire_vec(retire_vec),
    .limit     (lim_q),
    .room_vec  (room_vec),
    .acc_vec   (acc_vec)
  );

  bd_rr_pick #(.NUM_CORES(NUM_CORES), .CORE_W(CORE_W)) pick_i (
    .req(room_vec),
    .ptr(ptr_q),
    .hit(hit),
    .idx(pick_idx)
  );

  assign retired_cnt = BLK_W'($countones(acc_vec));
  assign fire        = (st_q == BD_RUN) && (nxt_q < grid_q) && hit;
  assign grant_vec   = fire ? (NUM_CORES'(1) << pick_idx) : '0;

  // next-state
  always_comb begin
    st_n   = st_q;
    lim_n  = lim_q;
    grid_n = grid_q;
    nxt_n  = nxt_q;
    fin_n  = fin_q;
    ptr_n  = ptr_q;
    clr    = 1'b0;
    if (launch && (st_q != BD_RUN)) begin
      clr    = 1'b1;
      lim_n  = lim_calc;
      grid_n = grid_blocks;
      nxt_n  = '0;
      fin_n  = '0;
      ptr_n  = '0;
      if (lim_calc == '0)         st_n = BD_FAULT;
      else if (grid_blocks == '0) st_n = BD_FIN;
      else                        st_n = BD_RUN;
    end else if (st_q == BD_RUN) begin
      if (fire) begin
        nxt_n = nxt_q + 1'b1;
        ptr_n = (pick_idx == CORE_W'(NUM_CORES - 1)) ? '0 : pick_idx + 1'b1;
      end
      fin_n = fin_q + retired_cnt;
      if (fin_n == grid_q) st_n = BD_FIN;
    end
  end

  assign ctl_en = clr || (st_q == BD_RUN);

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      st_q   <= BD_IDLE;
      lim_q  <= '0;
      grid_q <= '0;
      nxt_q  <= '0;
      fin_q  <= '0;
      ptr_q  <= '0;
    end else if (ctl_en) begin
      st_q   <= st_n;
      lim_q  <= lim_n;
      grid_q <= grid_n;
      nxt_q  <= nxt_n;
      fin_q  <= fin_n;
      ptr_q  <= ptr_n;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) dv_q <= 1'b0;
    else            dv_q <= fire;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      db_q <= '0;
      dc_q <= '0;
    end else if (fire) begin
      db_q <= nxt_q;
      dc_q <= pick_idx;
    end
  end

  assign disp_valid = dv_q;
  assign disp_blk   = db_q;
  assign disp_core  = dc_q;
  assign kern_done  = (st_q == BD_FIN);
  assign kern_err   = (st_q == BD_FAULT);
endmodule

// File: rtl/blk_dispatch_chk.sv
module blk_dispatch_chk #(
  parameter int NUM_CORES = 4,
  parameter int SLOT_MAX  = 8,
  parameter int BLK_W     = 16,
  parameter int CORE_W    = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 launch,
  input logic [BLK_W-1:0]     grid_blocks,
  input logic [NUM_CORES-1:0] retire_vec,
  input logic                 disp_valid,
  input logic [BLK_W-1:0]     disp_blk,
  input logic [CORE_W-1:0]    disp_core,
  input logic                 kern_done,
  input logic                 kern_err
);
  localparam int OCC_W = $clog2(SLOT_MAX + 2) + 1;

  logic             run_f, take;
  logic [BLK_W-1:0] c_next, c_grid;
  logic [OCC_W-1:0] occ [NUM_CORES];
  logic             over;

  assign take = launch && (!run_f || kern_done || kern_err);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_f  <= 1'b0;
      c_next <= '0;
      c_grid <= '0;
    end else if (take) begin
      run_f  <= 1'b1;
      c_next <= '0;
      c_grid <= grid_blocks;
    end else begin
      if (kern_done || kern_err) run_f <= 1'b0;
      if (disp_valid) c_next <= c_next + 1'b1;
    end
  end

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_occ
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   occ[c] <= '0;
      else if (take) occ[c] <= '0;
      else occ[c] <= occ[c]
                   + OCC_W'(disp_valid && (disp_core == CORE_W'(c)))
                   - OCC_W'(retire_vec[c] && (occ[c] != '0));
    end
  end

  always_comb begin
    over = 1'b0;
    for (int c = 0; c < NUM_CORES; c++) begin
      if (occ[c] > OCC_W'(SLOT_MAX)) over = 1'b1;
    end
  end

  AST_BLK_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> disp_blk == c_next);                       // R3
  AST_BLK_IN_GRID: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> disp_blk < c_grid);                        // R3
  AST_FAULT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    kern_err |-> !disp_valid);                                // R7
  AST_DONE_AFTER_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(kern_done) |-> c_next == c_grid);                   // R8
  AST_SLOT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    !over);                                                   // R2
endmodule

bind blk_dispatch blk_dispatch_chk #(
  .NUM_CORES(NUM_CORES), .SLOT_MAX(SLOT_MAX), .BLK_W(BLK_W), .CORE_W(CORE_W)
) chk_i (.*);

// File: tb/blk_dispatch_tb_top.sv
module blk_dispatch_tb_top;
  localparam int NC = 4;
  localparam int SM = 8;
  localparam int BW = 16;
  localparam int RW = 16;
  localparam int CW = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          launch;
  logic [BW-1:0] grid_blocks;
  logic [RW-1:0] regs_per_blk, smem_per_blk, core_regs, core_smem;
  logic [NC-1:0] retire_vec;
  logic          disp_valid;
  logic [BW-1:0] disp_blk;
  logic [CW-1:0] disp_core;
  logic          kern_done, kern_err;

  always #2.5 clk = ~clk;

  blk_dispatch #(.NUM_CORES(NC), .SLOT_MAX(SM), .BLK_W(BW), .RES_W(RW)) dut_i (
    .clk(clk), .rst_n(rst_n), .launch(launch), .grid_blocks(grid_blocks),
    .regs_per_blk(regs_per_blk), .smem_per_blk(smem_per_blk),
    .core_regs(core_regs), .core_smem(core_smem), .retire_vec(retire_vec),
    .disp_valid(disp_valid), .disp_blk(disp_blk), .disp_core(disp_core),
    .kern_done(kern_done), .kern_err(kern_err)
  );

  typedef struct { int blk; int core; string req; } exp_t;
  exp_t exp_q[$];
  exp_t cur;
  int checks = 0;
  int errors = 0;
  int seen   = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic push(input int blk, input int core, input string req);
    exp_t e;
    e.blk = blk; e.core = core; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start(input int grid, input int rpb, input int spb,
                       input int rcap, input int scap);
    @(negedge clk);
    grid_blocks  = BW'(grid);
    regs_per_blk = RW'(rpb);
    smem_per_blk = RW'(spb);
    core_regs    = RW'(rcap);
    core_smem    = RW'(scap);
    launch       = 1'b1;
    @(negedge clk);
    launch       = 1'b0;
  endtask

  task automatic retire(input logic [NC-1:0] m);
    @(negedge clk);
    retire_vec = m;
    @(negedge clk);
    retire_vec = '0;
  endtask

  // monitor: compare every dispatch against the scoreboard (R6: one per cycle)
  always @(negedge clk) begin
    if (rst_n && disp_valid && !finished) begin
      seen++;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3", "unexpected dispatch block", int'(disp_blk), -1);
      end else begin
        cur = exp_q.pop_front();
        chk(int'(disp_blk) == cur.blk, cur.req, "block index", int'(disp_blk), cur.blk);
        if (cur.core >= 0)
          chk(int'(disp_core) == cur.core, cur.req, "target core", int'(disp_core), cur.core);
      end
    end
  end

  task automatic summary();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    chk(1'b0, "R6", "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    int base;
    rst_n = 1'b0; launch = 1'b0; retire_vec = '0; grid_blocks = '0;
    regs_per_blk = '0; smem_per_blk = '0; core_regs = '0; core_smem = '0;
    idle(4);
    rst_n = 1'b1;
    idle(4);
    // R6: reset state
    chk(disp_valid == 1'b0, "R6", "disp_valid after reset", int'(disp_valid), 0);
    chk(kern_done == 1'b0, "R6", "kern_done after reset", int'(kern_done), 0);
    chk(kern_err == 1'b0, "R6", "kern_err after reset", int'(kern_err), 0);

    // kernel A: registers bind, limit 64/16 = 4; 20 blocks
    for (int i = 0; i < 16; i++) push(i, i % NC, "R4");
    base = seen;
    start(20, 16, 100, 64, 1000);
    idle(24);
    chk(seen - base == 16, "R1", "blocks resident at register limit", seen - base, 16);
    chk(exp_q.size() == 0, "R1", "pending expectations", exp_q.size(), 0);
    // R10: launch while running ignored
    start(0, 0, 0, 0, 0);
    idle(3);
    chk(kern_done == 1'b0, "R10", "kern_done after ignored launch", int'(kern_done), 0);
    // R5: refill goes to the core that freed a slot
    push(16, 2, "R5");
    retire(4'b0100);
    idle(3);
    push(17, 0, "R5");
    retire(4'b0001);
    idle(3);
    push(18, 1, "R5");
    push(19, 3, "R5");
    retire(4'b1010);
    idle(4);
    chk(exp_q.size() == 0, "R5", "refills issued", exp_q.size(), 0);
    retire(4'b1111);
    retire(4'b1111);
    retire(4'b1111);
    chk(kern_done == 1'b0, "R8", "kern_done before last retire", int'(kern_done), 0);
    retire(4'b1111);
    chk(kern_done == 1'b1, "R8", "kern_done after last retire", int'(kern_done), 1);
    idle(3);
    chk(kern_done == 1'b1, "R8", "kern_done held", int'(kern_done), 1);

    // kernel B: zero register demand, shared memory binds 250/100 = 2; 10 blocks
    for (int i = 0; i < 8; i++) push(i, i % NC, "R1");
    base = seen;
    start(10, 0, 100, 0, 250);
    chk(kern_done == 1'b0, "R8", "launch clears kern_done", int'(kern_done), 0);
    idle(14);
    chk(seen - base == 8, "R1", "blocks resident at shared-memory limit", seen - base, 8);
    push(8, 0, "R4");
    push(9, 1, "R4");
    retire(4'b1111);
    idle(4);
    retire(4'b1111);
    idle(2);
    // cores 2 and 3 are now empty
    retire(4'b1100);
    idle(2);
    chk(kern_done == 1'b0, "R9", "done after retires on empty cores", int'(kern_done), 0);
    retire(4'b0011);
    chk(kern_done == 1'b1, "R9", "done after the real last retires", int'(kern_done), 1);

    // kernel C: no resource limit, slot count binds at 8; 40 blocks
    for (int i = 0; i < 32; i++) push(i, i % NC, "R2");
    base = seen;
    start(40, 0, 0, 0, 0);
    idle(40);
    chk(seen - base == 32, "R2", "blocks resident at slot limit", seen - base, 32);
    for (int i = 32; i < 40; i++) push(i, -1, "R3");
    for (int r = 0; r < 30; r++) begin
      if (kern_done) break;
      retire(4'b1111);
    end
    chk(seen - base == 40, "R3", "total dispatches", seen - base, 40);
    chk(kern_done == 1'b1, "R8", "kern_done after drain", int'(kern_done), 1);

    // kernel D: register demand above capacity -> limit zero
    base = seen;
    start(5, 100, 0, 64, 0);
    idle(10);
    chk(kern_err == 1'b1, "R7", "kern_err on zero limit", int'(kern_err), 1);
    chk(seen == base, "R7", "dispatches with zero limit", seen - base, 0);
    chk(kern_done == 1'b0, "R7", "kern_done with zero limit", int'(kern_done), 0);

    // kernel E: empty grid
    start(0, 16, 100, 64, 1000);
    chk(kern_err == 1'b0, "R7", "kern_err cleared by launch", int'(kern_err), 0);
    chk(kern_done == 1'b1, "R8", "kern_done for empty grid", int'(kern_done), 1);
    idle(3);
    chk(seen == base, "R8", "dispatches for empty grid", seen - base, 0);
    chk(exp_q.size() == 0, "R3", "leftover expectations", exp_q.size(), 0);
    summary();
  end
endmodule